// File: doc/BRIEF.md
# Synthesizer Register Latch and Reset Sequencer

This block sits behind the serial shifter of a frequency synthesizer. Each time a complete input word arrives with its valid strobe, the two lowest bits of the word choose where the rest of the word goes. The possible targets are the reference-divider latch, the feedback-divider latch, the function latch, and an initialization path that writes the function latch too. The upper field of the word is stored unchanged. The block also drives the divider counters and the charge pump. It generates a one-cycle counter reset that parks the reference, feedback and timeout counters at their load state and three-states the pump.

There are three ways to trigger that pulse. An initialization write fires it and arms a one-shot, so the next feedback-divider load fires it once more. Later feedback loads leave the counters alone until another initialization write arrives. A counter-hold bit in the function latch holds the counters and the pump quiet for as long as it stays set, without powering the device down.

Power-down has two sources. One is synchronous: it is set by an initialization write that requests it while the chip enable is high. The other is asynchronous and comes straight from the chip-enable pin going low. The latches keep their contents through a chip-enable power-down.

Top module: `pll_latch_seq`

## Requirements
- R1: The word's bits [1:0] select the target. 00 loads the reference latch, 01 the feedback latch, 10 the function latch, and 11 (initialization) also loads the function latch. The other latches are unchanged.
- R2: The selected latch stores word bits [23:2] unchanged, one clock after the strobe.
- R3: An initialization write drives cnt_reset high for exactly the one cycle after the strobe edge.
- R4: The first feedback-latch load after an initialization write fires the one-cycle pulse. A second load without a new initialization write does not.
- R5: Reference loads, function loads and unarmed feedback loads do not pulse cnt_reset when the hold bit is 0.
- R6: cp_tristate is high in every cycle in which cnt_reset is high, and low otherwise.
- R7: A synchronous power-down is set when an initialization write arrives with ce = 1 and payload bit 1 (PD1, word bit 3) = 1 and payload bit 2 (PD2, word bit 4) = 0. pwr_down is then high from the next cycle. A later function write with PD1 = 0 clears it.
- R8: An initialization write with PD1 = 1 and PD2 = 1 does not power the device down.
- R9: ce = 0 forces pwr_down high at once, without waiting for a clock. The latch contents are kept, and pwr_down falls when ce returns high.
- R10: Payload bit 0 (word bit 2) of the function latch is the counter hold. While it is 1, cnt_reset and cp_tristate stay high and pwr_down stays low. Writing it 0 releases them.
- R11: Reset clears all three latches to zero and leaves cnt_reset, cp_tristate and the synchronous power-down low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle strobe marking a complete word |
| word | input | 24 | Input word; bits [1:0] select the target latch |
| ce | input | 1 | Chip enable; low forces power-down |
| ref_latch | output | 22 | Reference-divider latch contents |
| ndiv_latch | output | 22 | Feedback-divider latch contents |
| func_latch | output | 22 | Function latch contents |
| cnt_reset | output | 1 | Counter reset to the load state |
| cp_tristate | output | 1 | Charge-pump three-state |
| pwr_down | output | 1 | Power-down request |

## Verification
The hardest state to reach is the armed one-shot. It can only be observed by issuing an initialization write and then two feedback loads in a row, with the second one expected to stay silent. The bench steps through the three power-up procedures in turn: initialization-word, chip-enable and counter-hold. Each procedure leaves the sequencer in the state the next one needs. The synchronous power-down is reached through an initialization word carrying the PD1=1, PD2=0 pattern with ce high. That is then contrasted with the PD2=1 pattern and with the chip-enable pin dropping between clock edges.

// File: rtl/pll_latch_pkg.sv
package pll_latch_pkg;
    localparam int CTRL_W = 2;

    typedef enum logic [CTRL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_NDIV = 2'b01,
        SEL_FUNC = 2'b10,
        SEL_INIT = 2'b11
    } ctrl_e;

    // bit positions inside the stored payload of the function latch
    localparam int HOLD_POS = 0;
    localparam int PD1_POS  = 1;
    localparam int PD2_POS  = 2;
endpackage

// File: rtl/pll_word_decode.sv
module pll_word_decode
    import pll_latch_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int PAY_W = WORD_W - CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic              ld_ref,
    output logic              ld_ndiv,
    output logic              ld_func,
    output logic              ld_init,
    output logic [PAY_W-1:0]  payload
);
    ctrl_e sel;

    always_comb begin
        sel     = ctrl_e'(word[CTRL_W-1:0]);
        payload = word[WORD_W-1:CTRL_W];
        ld_ref  = word_vld && (sel == SEL_REF);
        ld_ndiv = word_vld && (sel == SEL_NDIV);
        ld_func = word_vld && (sel == SEL_FUNC);
        ld_init = word_vld && (sel == SEL_INIT);
    end

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_ref, ld_ndiv, ld_func, ld_init}));
endmodule

// File: rtl/pll_reset_seq.sv
module pll_reset_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_ndiv,
    input  logic ld_func,
    input  logic ld_init,
    input  logic ce,
    input  logic pd1_in,
    input  logic pd2_in,
    input  logic hold,
    output logic cnt_reset,
    output logic cp_tristate,
    output logic sync_pd
);
    typedef struct packed {
        logic pulse;
        logic armed;
        logic spd;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pulse = 1'b0;
        if (ld_init) begin
            st_d.pulse = 1'b1;
            st_d.armed = 1'b1;
            st_d.spd   = ce && pd1_in && !pd2_in;
        end else if (ld_ndiv && st_q.armed) begin
            st_d.pulse = 1'b1;
            st_d.armed = 1'b0;
        end
        if (ld_func && !pd1_in) begin
            st_d.spd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_reset   = st_q.pulse || hold;
    assign cp_tristate = st_q.pulse || hold;
    assign sync_pd     = st_q.spd;

    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |-> $past(ld_init || ld_ndiv));
    // R4
    arm_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ndiv && st_q.armed) |=> cnt_reset);
    // R4
    arm_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ndiv && !st_q.armed) |=> !st_q.pulse);
    // R7
    spd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_init && ce && pd1_in && !pd2_in) |=> sync_pd);
endmodule

// File: rtl/pll_latch_seq.sv
module pll_latch_seq
    import pll_latch_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int PAY_W = WORD_W - CTRL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    input  logic              ce,
    output logic [PAY_W-1:0]  ref_latch,
    output logic [PAY_W-1:0]  ndiv_latch,
    output logic [PAY_W-1:0]  func_latch,
    output logic              cnt_reset,
    output logic              cp_tristate,
    output logic              pwr_down
);
    typedef struct packed {
        logic [PAY_W-1:0] rref;
        logic [PAY_W-1:0] ndiv;
        logic [PAY_W-1:0] func;
    } lat_t;

    lat_t lat_d, lat_q;
    logic ld_ref, ld_ndiv, ld_func, ld_init;
    logic [PAY_W-1:0] payload;
    logic sync_pd;

    pll_word_decode #(.WORD_W(WORD_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word     (word),
        .ld_ref   (ld_ref),
        .ld_ndiv  (ld_ndiv),
        .ld_func  (ld_func),
        .ld_init  (ld_init),
        .payload  (payload)
    );

    always_comb begin
        lat_d = lat_q;
        if (ld_ref)             lat_d.rref = payload;
        if (ld_ndiv)            lat_d.ndiv = payload;
        if (ld_func || ld_init) lat_d.func = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    pll_reset_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_ndiv     (ld_ndiv),
        .ld_func     (ld_func),
        .ld_init     (ld_init),
        .ce          (ce),
        .pd1_in      (payload[PD1_POS]),
        .pd2_in      (payload[PD2_POS]),
        .hold        (lat_q.func[HOLD_POS]),
        .cnt_reset   (cnt_reset),
        .cp_tristate (cp_tristate),
        .sync_pd     (sync_pd)
    );

    assign ref_latch  = lat_q.rref;
    assign ndiv_latch = lat_q.ndiv;
    assign func_latch = lat_q.func;
    assign pwr_down   = !ce || sync_pd;

    // R2
    ref_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word[CTRL_W-1:0] == SEL_REF) |=> ref_latch == $past(word[WORD_W-1:CTRL_W]));
    // R9
    ce_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !word_vld) |=> ($stable(func_latch) && $stable(ref_latch) && $stable(ndiv_latch)));
    // R10
    hold_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (func_latch[HOLD_POS] && ce && !$past(ld_init)) |-> (cnt_reset && (pwr_down == sync_pd)));
endmodule

// File: tb/pll_latch_seq_test.sv
module pll_latch_seq_test;
    localparam int WORD_W = 24;
    localparam int PAY_W  = WORD_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_vld = 1'b0;
    logic [WORD_W-1:0] word = '0;
    logic ce = 1'b1;
    logic [PAY_W-1:0] ref_latch, ndiv_latch, func_latch;
    logic cnt_reset, cp_tristate, pwr_down;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pll_latch_seq #(.WORD_W(WORD_W)) uut (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word), .ce(ce),
        .ref_latch(ref_latch), .ndiv_latch(ndiv_latch), .func_latch(func_latch),
        .cnt_reset(cnt_reset), .cp_tristate(cp_tristate), .pwr_down(pwr_down)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] ctrl, input logic [PAY_W-1:0] pay);
        @(negedge clk);
        word = {pay, ctrl};
        word_vld = 1'b1;
        @(negedge clk);
        word_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(ref_latch == 0 && ndiv_latch == 0 && func_latch == 0, "R11 latches", {10'b0, ref_latch}, 0);
        chk(cnt_reset == 0 && cp_tristate == 0, "R11 reset outs", {30'b0, cnt_reset, cp_tristate}, 0);
        chk(pwr_down == 0, "R11 no pd", {31'b0, pwr_down}, 0);
    endtask

    task automatic t_init_method;
        send(2'b11, 22'h0ABC8);
        chk(func_latch == 22'h0ABC8, "R1 init to func", {10'b0, func_latch}, 32'h0ABC8);
        chk(cnt_reset == 1, "R3 init pulse", {31'b0, cnt_reset}, 1);
        chk(cp_tristate == 1, "R6 tristate with pulse", {31'b0, cp_tristate}, 1);
        idle(1);
        chk(cnt_reset == 0, "R3 pulse one wide", {31'b0, cnt_reset}, 0);
        chk(cp_tristate == 0, "R6 tristate drops", {31'b0, cp_tristate}, 0);
        send(2'b00, 22'h2A5A5);
        chk(ref_latch == 22'h2A5A5, "R2 ref stored", {10'b0, ref_latch}, 32'h2A5A5);
        chk(cnt_reset == 0, "R5 ref no pulse", {31'b0, cnt_reset}, 0);
        chk(ndiv_latch == 0 && func_latch == 22'h0ABC8, "R1 others kept", {10'b0, ndiv_latch}, 0);
        send(2'b01, 22'h13579B);
        chk(ndiv_latch == 22'h13579B, "R2 ndiv stored", {10'b0, ndiv_latch}, 32'h13579B);
        chk(cnt_reset == 1, "R4 first N pulse", {31'b0, cnt_reset}, 1);
        idle(1);
        send(2'b01, 22'h00111);
        chk(ndiv_latch == 22'h00111, "R2 ndiv second", {10'b0, ndiv_latch}, 32'h111);
        chk(cnt_reset == 0, "R4 second N silent", {31'b0, cnt_reset}, 0);
        send(2'b10, 22'h1F0F0);
        chk(func_latch == 22'h1F0F0, "R1 func stored", {10'b0, func_latch}, 32'h1F0F0);
        chk(cnt_reset == 0, "R5 func no pulse", {31'b0, cnt_reset}, 0);
        chk(pwr_down == 0, "R7 no pd yet", {31'b0, pwr_down}, 0);
    endtask

    task automatic t_sync_pd;
        send(2'b11, 22'h00002);
        chk(pwr_down == 1, "R7 sync pd set", {31'b0, pwr_down}, 1);
        idle(2);
        chk(pwr_down == 1, "R7 sync pd holds", {31'b0, pwr_down}, 1);
        send(2'b10, 22'h00000);
        chk(pwr_down == 0, "R7 sync pd cleared", {31'b0, pwr_down}, 0);
        send(2'b11, 22'h00006);
        chk(pwr_down == 0, "R8 pd2 blocks", {31'b0, pwr_down}, 0);
        send(2'b01, 22'h00222);
        chk(cnt_reset == 1, "R4 rearmed N pulse", {31'b0, cnt_reset}, 1);
        idle(1);
    endtask

    task automatic t_ce_method;
        @(negedge clk);
        ce = 1'b0;
        #1;
        chk(pwr_down == 1, "R9 async pd", {31'b0, pwr_down}, 1);
        send(2'b10, 22'h00C30);
        send(2'b00, 22'h00077);
        send(2'b01, 22'h00345);
        idle(3);
        chk(func_latch == 22'h00C30 && ref_latch == 22'h00077 && ndiv_latch == 22'h00345,
            "R9 latches kept", {10'b0, ndiv_latch}, 32'h345);
        ce = 1'b1;
        #1;
        chk(pwr_down == 0, "R9 pd released", {31'b0, pwr_down}, 0);
        chk(ref_latch == 22'h00077, "R9 ref after ce", {10'b0, ref_latch}, 32'h77);
    endtask

    task automatic t_hold_method;
        send(2'b10, 22'h00001);
        chk(cnt_reset == 1 && cp_tristate == 1, "R10 hold active", {30'b0, cnt_reset, cp_tristate}, 3);
        send(2'b00, 22'h00ABC);
        send(2'b01, 22'h00DEF);
        idle(2);
        chk(cnt_reset == 1, "R10 hold persists", {31'b0, cnt_reset}, 1);
        chk(cp_tristate == 1, "R6 tristate in hold", {31'b0, cp_tristate}, 1);
        chk(pwr_down == 0, "R10 hold no pd", {31'b0, pwr_down}, 0);
        send(2'b10, 22'h00000);
        chk(cnt_reset == 0 && cp_tristate == 0, "R10 hold released", {30'b0, cnt_reset, cp_tristate}, 0);
        chk(ndiv_latch == 22'h00DEF, "R2 ndiv in hold", {10'b0, ndiv_latch}, 32'hDEF);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_init_method();
        t_sync_pd();
        t_ce_method();
        t_hold_method();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule